// File: doc/BRIEF.md
# Byte-Wide Parallel Port Receiver

The block receives bytes from a host over an 8-bit compatibility-mode parallel port on the printer side. The host places a byte on the data lines and pulls the active-low strobe low. The block passes the strobe through a two-flop synchroniser and detects its falling edge. At that edge it captures the byte into an internal receive FIFO and raises BUSY on the same clock edge. It then drives an active-low acknowledge pulse of a fixed number of clock cycles. One cycle after the acknowledge returns high, BUSY drops and the port is free for the next byte.

Local logic drains the FIFO through a pop port that shows the oldest byte along with empty and full flags. When the FIFO is full, BUSY stays high and strobes are ignored until a byte is popped. The host's active-low init line, once synchronised, can flush the FIFO and abort a handshake in progress. A configuration input enables or disables this. Three status inputs are passed to the host lines for paper out, online and fault. The fault line is active-low.

Top module: `lpt_byte_rx`

## Requirements
- R1: The byte on `hst_data_i` is written into the FIFO on the clock edge at which the synchronised strobe is first seen low. This is the third rising edge after the strobe falls. The byte then appears on `rd_data_o` with `empty_o` low.
- R2: `hst_busy_o` rises on the same edge that writes the byte, and `hst_ack_no` falls on that edge as well.
- R3: `hst_ack_no` stays low for exactly ACK_CYCLES clock cycles per accepted byte, and `hst_busy_o` is high throughout.
- R4: After `hst_ack_no` returns high, `hst_busy_o` stays high for one more cycle. It then goes low, provided the FIFO is not full.
- R5: A strobe falling edge detected while a handshake is in progress is ignored, and no byte is written for it.
- R6: While `full_o` is high, `hst_busy_o` is high and strobes are ignored. BUSY drops in the cycle after a pop frees space.
- R7: With `prime_en_i` high, a low level on `hst_init_ni` empties the FIFO (two clock cycles after synchronisation) and returns the handshake to idle, with BUSY low and ACK high. This holds even in the middle of an acknowledge pulse.
- R8: With `prime_en_i` low, `hst_init_ni` has no effect on the FIFO contents or the handshake.
- R9: `hst_paper_out_o` follows `paper_out_i` and `hst_online_o` follows `online_i`. `hst_fault_no` is the inverse of `fault_i`.
- R10: The FIFO returns bytes in arrival order. A pop (`pop_i` high with `empty_o` low) removes the oldest byte, and `empty_o` rises once the last byte is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prime_en_i | input | 1 | Enables host init to clear the receiver |
| hst_data_i | input | 8 | Host data lines |
| hst_strobe_ni | input | 1 | Host strobe, active low, asynchronous |
| hst_init_ni | input | 1 | Host init/prime, active low, asynchronous |
| hst_busy_o | output | 1 | BUSY to host |
| hst_ack_no | output | 1 | Acknowledge pulse to host, active low |
| hst_paper_out_o | output | 1 | Paper-out status to host |
| hst_online_o | output | 1 | Online/select status to host |
| hst_fault_no | output | 1 | Fault status to host, active low |
| paper_out_i | input | 1 | Local paper-out status |
| online_i | input | 1 | Local online status |
| fault_i | input | 1 | Local fault status |
| pop_i | input | 1 | Remove the oldest FIFO byte |
| rd_data_o | output | 8 | Oldest FIFO byte |
| empty_o | output | 1 | FIFO empty |
| full_o | output | 1 | FIFO full |

## Verification
The assertions check the following on every cycle:
- acknowledge low implies BUSY high;
- full implies BUSY;
- a BUSY rise comes with an acknowledge fall;
- every unaborted acknowledge pulse is exactly ACK_CYCLES long;
- no write ever hits a full FIFO;
- a prime leaves the FIFO empty and BUSY low.

Only the bench's scenarios can show the rest. These are the exact edge on which a byte is captured after the strobe falls, that the captured value and the FIFO order are right, and that strobes during a handshake or while full are really dropped. They also cover the fact that init does nothing when prime is disabled, and the mapping of the status lines.

// File: rtl/lpt_rx_pkg.sv
package lpt_rx_pkg;
  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_ACK  = 2'd1,
    HS_POST = 2'd2
  } hs_state_e;
endpackage

// File: rtl/lpt_sync.sv
module lpt_sync #(
  parameter int unsigned WIDTH = 1,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL;
        s2_q <= RST_VAL;
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/lpt_fifo.sv
module lpt_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW:0]   wptr_q, rptr_q;
  logic          do_pop;

  assign empty_o = (wptr_q == rptr_q);
  assign full_o  = (wptr_q[AW] != rptr_q[AW]) && (wptr_q[AW-1:0] == rptr_q[AW-1:0]);
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rptr_q[AW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (push_i && !full_o) wptr_q <= wptr_q + 1'b1;
      if (do_pop)            rptr_q <= rptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o && !flush_i) mem_q[wptr_q[AW-1:0]] <= wdata_i;
  end
endmodule

// File: rtl/lpt_hs_fsm.sv
module lpt_hs_fsm
  import lpt_rx_pkg::*;
#(
  parameter int unsigned ACK_CYCLES = 1250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fall_i,
  input  logic full_i,
  input  logic prime_i,
  output logic push_o,
  output logic busy_o,
  output logic ack_no
);
  localparam int unsigned CW = $clog2(ACK_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(ACK_CYCLES - 1);

  hs_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign push_o = (state_q == HS_IDLE) && fall_i && !full_i && !prime_i;
  assign busy_o = (state_q != HS_IDLE) || full_i;
  assign ack_no = (state_q != HS_ACK);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (prime_i) begin
      state_d = HS_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        HS_IDLE: if (push_o) begin
          state_d = HS_ACK;
          cnt_d   = '0;
        end
        HS_ACK: begin
          if (cnt_q == CNT_LAST) state_d = HS_POST;
          else                   cnt_d   = cnt_q + 1'b1;
        end
        HS_POST: state_d = HS_IDLE;
        default: state_d = HS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HS_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/lpt_byte_rx.sv
module lpt_byte_rx #(
  parameter int unsigned ACK_CYCLES = 1250,
  parameter int unsigned DEPTH      = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       prime_en_i,
  input  logic [7:0] hst_data_i,
  input  logic       hst_strobe_ni,
  input  logic       hst_init_ni,
  output logic       hst_busy_o,
  output logic       hst_ack_no,
  output logic       hst_paper_out_o,
  output logic       hst_online_o,
  output logic       hst_fault_no,
  input  logic       paper_out_i,
  input  logic       online_i,
  input  logic       fault_i,
  input  logic       pop_i,
  output logic [7:0] rd_data_o,
  output logic       empty_o,
  output logic       full_o
);
  logic [1:0] sync_q;
  logic       strobe_s, init_s, strobe_prev_q;
  logic       fall, prime_act, push;

  lpt_sync #(.WIDTH(2), .RST_VAL(1'b1)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({hst_init_ni, hst_strobe_ni}),
    .q_o   (sync_q)
  );
  assign strobe_s = sync_q[0];
  assign init_s   = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_prev_q <= 1'b1;
    else         strobe_prev_q <= strobe_s;
  end

  assign fall      = strobe_prev_q && !strobe_s;
  assign prime_act = prime_en_i && !init_s;

  lpt_hs_fsm #(.ACK_CYCLES(ACK_CYCLES)) i_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fall_i (fall),
    .full_i (full_o),
    .prime_i(prime_act),
    .push_o (push),
    .busy_o (hst_busy_o),
    .ack_no (hst_ack_no)
  );

  lpt_fifo #(.DW(8), .DEPTH(DEPTH)) i_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(prime_act),
    .push_i (push),
    .wdata_i(hst_data_i),
    .pop_i  (pop_i),
    .rdata_o(rd_data_o),
    .empty_o(empty_o),
    .full_o (full_o)
  );

  assign hst_paper_out_o = paper_out_i;
  assign hst_online_o    = online_i;
  assign hst_fault_no    = !fault_i;
endmodule

// File: rtl/lpt_rx_chk.sv
module lpt_rx_chk #(
  parameter int unsigned ACK_CYCLES = 1250
) (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_i,
  input logic ack_ni,
  input logic full_i,
  input logic empty_i,
  input logic push_i,
  input logic prime_i
);
  logic [31:0] lo_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lo_cnt_q <= '0;
    else if (!ack_ni) lo_cnt_q <= lo_cnt_q + 1;
    else             lo_cnt_q <= '0;
  end

  a_r3_ack_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_ni |-> busy_i);

  a_r2_busy_with_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> !ack_ni);

  a_r3_ack_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ack_ni) && !$past(prime_i)) |-> (lo_cnt_q == ACK_CYCLES));

  a_r6_full_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_i |-> busy_i);

  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && full_i));

  a_r7_prime_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prime_i |=> (empty_i && !busy_i && ack_ni));
endmodule

bind lpt_byte_rx lpt_rx_chk #(.ACK_CYCLES(ACK_CYCLES)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .busy_i (hst_busy_o),
  .ack_ni (hst_ack_no),
  .full_i (full_o),
  .empty_i(empty_o),
  .push_i (push),
  .prime_i(prime_act)
);

// File: tb/test_lpt_byte_rx.sv
module test_lpt_byte_rx;
  localparam int ACK = 10;
  localparam int DEP = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic prime_en = 1'b0, strobe_n = 1'b1, init_n = 1'b1, pop = 1'b0;
  logic [7:0] data = 8'h00;
  logic paper_out = 1'b0, online = 1'b0, fault = 1'b0;
  logic busy, ack_n, pe_o, onl_o, flt_no, empty, full;
  logic [7:0] rd;
  int total = 0, bad = 0, cyc = 0;

  always #2 clk = ~clk;

  lpt_byte_rx #(.ACK_CYCLES(ACK), .DEPTH(DEP)) i_lpt_byte_rx (
    .clk_i(clk), .rst_ni(rst_n), .prime_en_i(prime_en),
    .hst_data_i(data), .hst_strobe_ni(strobe_n), .hst_init_ni(init_n),
    .hst_busy_o(busy), .hst_ack_no(ack_n),
    .hst_paper_out_o(pe_o), .hst_online_o(onl_o), .hst_fault_no(flt_no),
    .paper_out_i(paper_out), .online_i(online), .fault_i(fault),
    .pop_i(pop), .rd_data_o(rd), .empty_o(empty), .full_o(full)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog: act=%0d exp<=100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(logic [7:0] b);
    @(negedge clk); data = b; strobe_n = 1'b0;
    repeat (3) @(negedge clk);
    strobe_n = 1'b1;
  endtask

  task automatic settle();
    for (int i = 0; i < ACK + 8; i++) @(negedge clk);
  endtask

  task automatic pop_one();
    @(negedge clk); pop = 1'b1;
    @(negedge clk); pop = 1'b0;
  endtask

  task automatic t_reset();
    chk("R2 reset busy", busy, 0);
    chk("R3 reset ack", ack_n, 1);
    chk("R10 reset empty", empty, 1);
    chk("R6 reset full", full, 0);
  endtask

  task automatic t_timing();
    int n;
    @(negedge clk); data = 8'hA5; strobe_n = 1'b0;
    @(negedge clk);
    chk("R2 busy edge1", busy, 0);
    @(negedge clk);
    chk("R2 busy edge2", busy, 0);
    chk("R1 empty edge2", empty, 1);
    @(negedge clk);
    chk("R2 busy edge3", busy, 1);
    chk("R2 ack edge3", ack_n, 0);
    chk("R1 captured", rd, 8'hA5);
    data = 8'h00; strobe_n = 1'b1;
    n = 1;
    for (int i = 0; i < 4 * ACK; i++) begin
      @(negedge clk);
      if (!ack_n) begin
        n++;
        chk("R3 busy during ack", busy, 1);
      end else break;
    end
    chk("R3 ack width", n, ACK);
    chk("R4 busy after ack", busy, 1);
    @(negedge clk);
    chk("R4 busy dropped", busy, 0);
    chk("R1 empty", empty, 0);
    pop_one();
    chk("R10 empty after pop", empty, 1);
  endtask

  task automatic t_ignore_busy();
    strobe(8'h5A);
    strobe(8'h3C);
    settle();
    chk("R5 first byte", rd, 8'h5A);
    pop_one();
    chk("R5 second dropped", empty, 1);
  endtask

  task automatic t_full();
    int lows;
    for (int k = 0; k < DEP; k++) begin
      strobe(8'h10 + 8'(k));
      settle();
    end
    chk("R6 full", full, 1);
    chk("R6 busy held", busy, 1);
    lows = 0;
    @(negedge clk); data = 8'h99; strobe_n = 1'b0;
    for (int i = 0; i < ACK + 8; i++) begin
      @(negedge clk);
      if (i == 3) strobe_n = 1'b1;
      if (!ack_n) lows++;
    end
    chk("R6 no ack when full", lows, 0);
    chk("R6 busy still", busy, 1);
    chk("R10 head", rd, 8'h10);
    pop_one();
    chk("R6 busy after pop", busy, 0);
    for (int k = 1; k < DEP; k++) begin
      chk("R10 order", rd, 8'h10 + k);
      pop_one();
    end
    chk("R6 strobe dropped", empty, 1);
  endtask

  task automatic t_prime();
    prime_en = 1'b0;
    strobe(8'h21); settle();
    strobe(8'h22); settle();
    @(negedge clk); init_n = 1'b0;
    repeat (6) @(negedge clk);
    chk("R8 not flushed", empty, 0);
    chk("R8 head kept", rd, 8'h21);
    init_n = 1'b1;
    repeat (4) @(negedge clk);
    prime_en = 1'b1;
    @(negedge clk); init_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7 flushed", empty, 1);
    chk("R7 busy low", busy, 0);
    init_n = 1'b1;
    repeat (4) @(negedge clk);
    strobe(8'h33);
    chk("R7 in ack", ack_n, 0);
    init_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7 abort busy", busy, 0);
    chk("R7 abort ack", ack_n, 1);
    chk("R7 abort empty", empty, 1);
    init_n = 1'b1;
    repeat (4) @(negedge clk);
    prime_en = 1'b0;
  endtask

  task automatic t_status();
    @(negedge clk); paper_out = 1'b1; online = 1'b0; fault = 1'b1;
    @(negedge clk);
    chk("R9 paper", pe_o, 1);
    chk("R9 online", onl_o, 0);
    chk("R9 fault", flt_no, 0);
    paper_out = 1'b0; online = 1'b1; fault = 1'b0;
    @(negedge clk);
    chk("R9 paper2", pe_o, 0);
    chk("R9 online2", onl_o, 1);
    chk("R9 fault2", flt_no, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_timing();
    t_ignore_busy();
    t_full();
    t_prime();
    t_status();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule